// File: doc/BRIEF.md
# DMA descriptor vetter

This block sits beside a DMA engine's descriptor fetch path and judges each descriptor before any payload moves. The descriptor arrives as sixteen 32-bit words, one per accepted beat, with word 0 first. The channel number (0 to 5) is sampled with word 0. While the words stream in, the block keeps a running 32-bit sum and keeps the control word (word 0) and the timestamp-high word (word 5). One cycle after word 15 is accepted, it gives a one-cycle verdict. The verdict is either a pass or exactly one error class, and a fail also carries the error-bank bit for that channel.

When a descriptor passes, the verdict also carries the channel's status word, a chain-end flag, a completion-event bit, and a write-back request holding word 5 with its done flag set. The fetch logic can raise a fetch-error strobe at any time. That strobe aborts any partly collected descriptor and is reported on the next cycle. It takes priority over every other check.

Top module: `dscr_vetter`

## Requirements
- R1: `res_valid` is high for exactly one cycle, in the cycle after the 16th accepted beat (`in_valid` high with `fetch_err` low) or after a `fetch_err` cycle, and is low in every other cycle. Beats may be separated by any number of idle cycles.
- R2: A descriptor whose word 0 bits [7:0] differ from 0xA5 fails with class 2 and error bit 7+ch.
- R3: When word 0 bit 20 is set and the 32-bit wrapping sum of words 0 to 14 differs from word 15, the descriptor fails with class 3 and error bit 13+ch. When bit 20 is clear, word 15 is not checked.
- R4: When word 5 bit 31 (done) is set and word 0 bit 10 (ignore-done) is clear, the descriptor fails with class 4 and error bit 25+ch. When bit 10 is set, the done flag causes no failure.
- R5: Checks are ranked fetch error, then preamble, then checksum, then done. Only the first failing check is reported, so `err_bits` has at most one bit set. A pass reports class 0 with `res_pass` high and `err_bits` zero.
- R6: `fetch_err` reports class 1 with error bit 1+ch on the next cycle. Here ch is the channel latched with word 0, or `in_chan` when no word of the current descriptor has been accepted yet. The partial descriptor and any beat in the same cycle are discarded, and the next beat is taken as word 0.
- R7: `chain_end` is high on a pass whose word 0 has bit 19 (last) or bit 21 (last of frame) set.
- R8: On a pass, `status_word` places word 0 bits [7:0] at bits [20:13]. It maps control bit 11 to status bit 4, bit 18 to 5, bit 20 to 6, bit 19 to 7, bit 21 to 8, bit 10 to 9, bit 9 to 11 and bit 8 to 12. Word 5 bit 31 goes to status bit 10, and all other status bits are zero.
- R9: On a pass with word 0 bit 8 set, `done_evt` has bit ch set. In all other cases it is zero.
- R10: On a pass with word 0 bit 9 set, `wb_req` is high and `wb_word` equals word 5 with bit 31 set.
- R11: While `rst` is high, and on every result that is not a pass, `status_word`, `chain_end`, `done_evt`, `wb_req` and `wb_word` are zero. Reset also discards a partly collected descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A descriptor word is offered this cycle |
| in_word | input | 32 | Descriptor word |
| in_chan | input | 3 | Channel number, sampled with word 0 or with an idle fetch error |
| fetch_err | input | 1 | Descriptor fetch failed; aborts the collection |
| res_valid | output | 1 | Verdict strobe |
| res_pass | output | 1 | Descriptor accepted |
| res_class | output | 3 | 0 pass, 1 fetch, 2 preamble, 3 checksum, 4 already done |
| err_bits | output | 32 | Error-bank bit for the failing check and channel |
| status_word | output | 32 | Channel status built from the descriptor |
| chain_end | output | 1 | Descriptor ends the chain |
| done_evt | output | 32 | Completion-event bank bit for the channel |
| wb_req | output | 1 | Word 5 must be written back |
| wb_word | output | 32 | Word 5 with the done flag set |

## Verification
Two functions can land in the same cycle: a fetch-error strobe and the final beat (word 15) that would otherwise complete a verdict. The bench drives word 15 with `in_valid` high in the same cycle as `fetch_err`. It expects a class-1 result carrying the latched channel, with no trace of the descriptor's own verdict. A complete descriptor sent afterwards must be judged from word 0. Aborts at word 0 with no collection in progress, and aborts in mid-descriptor, are checked the same way.

// File: rtl/dscr_vet_pkg.sv
package dscr_vet_pkg;

  localparam int DW = 32;

  // control word field positions (decoded by the engine, so fixed)
  localparam int PRE_LSB      = 0;
  localparam int PRE_W        = 8;
  localparam logic [7:0] PRE_VALUE = 8'hA5;
  localparam int C_CPL_IRQ    = 8;
  localparam int C_WB_EN      = 9;
  localparam int C_IGN_DONE   = 10;
  localparam int C_BURST      = 11;
  localparam int C_MODE       = 18;
  localparam int C_LAST       = 19;
  localparam int C_CSUM_EN    = 20;
  localparam int C_LAST_FRAME = 21;
  localparam int DONE_BIT     = 31;

  // error bank bases, offset by channel
  localparam int EB_FETCH = 1;
  localparam int EB_PRE   = 7;
  localparam int EB_CSUM  = 13;
  localparam int EB_DONE  = 25;

  typedef enum logic [2:0] {
    VC_PASS     = 3'd0,
    VC_FETCH    = 3'd1,
    VC_PREAMBLE = 3'd2,
    VC_CSUM     = 3'd3,
    VC_REPLAY   = 3'd4
  } verdict_e;

endpackage

// File: rtl/dscr_vet_collect.sv
module dscr_vet_collect
  import dscr_vet_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int FLAG_IDX  = 5,
  parameter int CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            beat,
  input  logic            abort,
  input  logic [DW-1:0]   word,
  input  logic [CH_W-1:0] chan,
  output logic            last_beat,
  output logic            idle,
  output logic [DW-1:0]   sum_q,
  output logic [DW-1:0]   ctrl_q,
  output logic [DW-1:0]   flag_q,
  output logic [CH_W-1:0] ch_q
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] F_IDX    = IDX_W'(FLAG_IDX);

  logic [IDX_W-1:0] idx;

  assign last_beat = beat && (idx == LAST_IDX);
  assign idle      = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst || abort || last_beat) begin
      idx   <= '0;
      sum_q <= '0;
    end else if (beat) begin
      idx   <= idx + 1'b1;
      sum_q <= sum_q + word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
      ch_q   <= '0;
    end else if (beat && !abort) begin
      if (idx == '0) begin
        ctrl_q <= word;
        ch_q   <= chan;
      end
      if (idx == F_IDX) flag_q <= word;
    end
  end

  // R3: the running sum always restarts from zero at a descriptor boundary
  p_sum_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> (sum_q == '0));

  // R6: an abort always sends collection back to word 0
  p_abort_restart_r6: assert property (@(posedge clk) disable iff (rst)
    abort |=> (idx == '0));

endmodule

// File: rtl/dscr_vet_judge.sv
module dscr_vet_judge
  import dscr_vet_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            fetch,
  input  logic [DW-1:0]   ctrl,
  input  logic [DW-1:0]   flag,
  input  logic [DW-1:0]   sum,
  input  logic [DW-1:0]   csum_word,
  input  logic [CH_W-1:0] ch,
  output verdict_e        cls,
  output logic [DW-1:0]   err
);
  logic pre_bad, csum_bad, replay;
  logic unused_judge;

  assign pre_bad  = ctrl[PRE_LSB +: PRE_W] != PRE_VALUE;
  assign csum_bad = ctrl[C_CSUM_EN] && (sum != csum_word);
  assign replay   = flag[DONE_BIT] && !ctrl[C_IGN_DONE];
  assign unused_judge = ^{ctrl[DW-1:C_CSUM_EN+1], ctrl[C_CSUM_EN-1:C_IGN_DONE+1],
                          ctrl[C_IGN_DONE-1:PRE_W], flag[DONE_BIT-1:0]};

  always_comb begin
    cls = VC_PASS;
    err = '0;
    if (fetch) begin
      cls = VC_FETCH;
      err = DW'(1) << (EB_FETCH + int'(ch));
    end else if (pre_bad) begin
      cls = VC_PREAMBLE;
      err = DW'(1) << (EB_PRE + int'(ch));
    end else if (csum_bad) begin
      cls = VC_CSUM;
      err = DW'(1) << (EB_CSUM + int'(ch));
    end else if (replay) begin
      cls = VC_REPLAY;
      err = DW'(1) << (EB_DONE + int'(ch));
    end
  end

endmodule

// File: rtl/dscr_vet_status.sv
module dscr_vet_status
  import dscr_vet_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            pass,
  input  logic [DW-1:0]   ctrl,
  input  logic [DW-1:0]   flag,
  input  logic [CH_W-1:0] ch,
  output logic [DW-1:0]   status,
  output logic            chain_end,
  output logic [DW-1:0]   evt,
  output logic            wb_req,
  output logic [DW-1:0]   wb_word
);
  logic [DW-1:0] built;
  logic unused_status;

  assign unused_status = ^{ctrl[DW-1:C_LAST_FRAME+1], ctrl[C_MODE-1:C_BURST+1]};

  always_comb begin
    built                    = '0;
    built[20:13]             = ctrl[PRE_LSB +: PRE_W];
    built[4]                 = ctrl[C_BURST];
    built[5]                 = ctrl[C_MODE];
    built[6]                 = ctrl[C_CSUM_EN];
    built[7]                 = ctrl[C_LAST];
    built[8]                 = ctrl[C_LAST_FRAME];
    built[9]                 = ctrl[C_IGN_DONE];
    built[10]                = flag[DONE_BIT];
    built[11]                = ctrl[C_WB_EN];
    built[12]                = ctrl[C_CPL_IRQ];
  end

  assign status    = pass ? built : '0;
  assign chain_end = pass && (ctrl[C_LAST] || ctrl[C_LAST_FRAME]);
  assign evt       = (pass && ctrl[C_CPL_IRQ]) ? (DW'(1) << ch) : '0;
  assign wb_req    = pass && ctrl[C_WB_EN];
  assign wb_word   = wb_req ? (flag | (DW'(1) << DONE_BIT)) : '0;

endmodule

// File: rtl/dscr_vetter.sv
module dscr_vetter
  import dscr_vet_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int FLAG_IDX  = 5,
  parameter int NUM_CH    = 6,
  parameter int CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic [CH_W-1:0] in_chan,
  input  logic            fetch_err,
  output logic            res_valid,
  output logic            res_pass,
  output logic [2:0]      res_class,
  output logic [31:0]     err_bits,
  output logic [31:0]     status_word,
  output logic            chain_end,
  output logic [31:0]     done_evt,
  output logic            wb_req,
  output logic [31:0]     wb_word
);
  logic            beat, last_beat, idle, fire;
  logic [DW-1:0]   sum_q, ctrl_q, flag_q;
  logic [CH_W-1:0] ch_q, ch_sel;
  verdict_e        cls;
  logic [DW-1:0]   err_c, stat_c, evt_c, wbw_c;
  logic            chain_c, wbr_c, pass_c;

  assign beat   = in_valid && !fetch_err;
  assign ch_sel = (fetch_err && idle) ? in_chan : ch_q;
  assign fire   = fetch_err || last_beat;

  dscr_vet_collect #(.NUM_WORDS(NUM_WORDS), .FLAG_IDX(FLAG_IDX), .CH_W(CH_W)) u_collect (
    .clk(clk), .rst(rst), .beat(beat), .abort(fetch_err), .word(in_word),
    .chan(in_chan), .last_beat(last_beat), .idle(idle), .sum_q(sum_q),
    .ctrl_q(ctrl_q), .flag_q(flag_q), .ch_q(ch_q)
  );

  dscr_vet_judge #(.CH_W(CH_W)) u_judge (
    .fetch(fetch_err), .ctrl(ctrl_q), .flag(flag_q), .sum(sum_q),
    .csum_word(in_word), .ch(ch_sel), .cls(cls), .err(err_c)
  );

  assign pass_c = (cls == VC_PASS);

  dscr_vet_status #(.CH_W(CH_W)) u_status (
    .pass(pass_c), .ctrl(ctrl_q), .flag(flag_q), .ch(ch_q),
    .status(stat_c), .chain_end(chain_c), .evt(evt_c),
    .wb_req(wbr_c), .wb_word(wbw_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !fire) begin
      res_valid   <= 1'b0;
      res_pass    <= 1'b0;
      res_class   <= '0;
      err_bits    <= '0;
      status_word <= '0;
      chain_end   <= 1'b0;
      done_evt    <= '0;
      wb_req      <= 1'b0;
      wb_word     <= '0;
    end else begin
      res_valid   <= 1'b1;
      res_pass    <= pass_c;
      res_class   <= cls;
      err_bits    <= err_c;
      status_word <= stat_c;
      chain_end   <= chain_c;
      done_evt    <= evt_c;
      wb_req      <= wbr_c;
      wb_word     <= wbw_c;
    end
  end

  // R1: no input activity, no verdict
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !fetch_err) |=> !res_valid);

  // R6: a fetch error is always reported as class 1 next cycle
  p_fetch_report_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_err |=> (res_valid && res_class == 3'd1));

  // R5: at most one error bit; pass exactly when none
  p_single_err_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($onehot0(err_bits) && (res_pass == (err_bits == '0))));

  // R11: failed or absent verdicts carry no pass-side outputs
  p_fail_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !res_pass |-> (!chain_end && !wb_req && done_evt == '0 && status_word == '0));

  // R9: completion event names a single channel, only on a pass
  p_evt_single_r9: assert property (@(posedge clk) disable iff (rst)
    (done_evt != '0) |-> (res_pass && $countones(done_evt) == 1));

  // R10: write-back always carries the done flag
  p_wb_flag_r10: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> wb_word[31]);

  // R6: channel number stays inside the configured range
  p_chan_range_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid || fetch_err) |-> (int'(in_chan) < NUM_CH));

endmodule

// File: tb/tb_dscr_vetter.sv
module tb_dscr_vetter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [2:0]  in_chan = '0;
  logic        fetch_err = 1'b0;
  logic        res_valid, res_pass, chain_end, wb_req;
  logic [2:0]  res_class;
  logic [31:0] err_bits, status_word, done_evt, wb_word;

  always #10 clk = ~clk;

  dscr_vetter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_chan(in_chan), .fetch_err(fetch_err), .res_valid(res_valid),
    .res_pass(res_pass), .res_class(res_class), .err_bits(err_bits),
    .status_word(status_word), .chain_end(chain_end), .done_evt(done_evt),
    .wb_req(wb_req), .wb_word(wb_word)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] d [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  function automatic logic [31:0] csum15();
    logic [31:0] s = '0;
    for (int k = 0; k < 15; k++) s += d[k];
    return s;
  endfunction

  // builds d[] with selected properties
  task automatic make_desc(input bit pre_ok, input bit cs_en, input bit cs_ok,
                           input bit done, input bit ign);
    for (int k = 0; k < 16; k++) d[k] = $urandom;
    d[0][7:0] = pre_ok ? 8'hA5 : (8'hA5 ^ 8'($urandom_range(1, 255)));
    d[0][20]  = cs_en;
    d[0][10]  = ign;
    d[5][31]  = done;
    d[15]     = csum15() + (cs_ok ? 32'd0 : 32'(1 + $urandom_range(0, 1000)));
  endtask

  task automatic check_verdict(input int ch);
    logic [2:0]  cls;
    logic [31:0] err, st, evt, wbw;
    logic        pass, ce, wbr;
    string       tg;
    cls = 3'd0; err = '0;
    if (d[0][7:0] != 8'hA5) begin cls = 3'd2; err = 32'd1 << (7 + ch); tg = "R2"; end
    else if (d[0][20] && csum15() != d[15]) begin cls = 3'd3; err = 32'd1 << (13 + ch); tg = "R3"; end
    else if (d[5][31] && !d[0][10]) begin cls = 3'd4; err = 32'd1 << (25 + ch); tg = "R4"; end
    else tg = "R5";
    pass = (cls == 3'd0);
    st = '0;
    if (pass) begin
      st[20:13] = d[0][7:0];
      st[4] = d[0][11]; st[5] = d[0][18]; st[6] = d[0][20]; st[7] = d[0][19];
      st[8] = d[0][21]; st[9] = d[0][10]; st[10] = d[5][31]; st[11] = d[0][9];
      st[12] = d[0][8];
    end
    ce  = pass && (d[0][19] || d[0][21]);
    evt = (pass && d[0][8]) ? (32'd1 << ch) : '0;
    wbr = pass && d[0][9];
    wbw = wbr ? (d[5] | 32'h8000_0000) : '0;
    chk("R1 res_valid", 32'(res_valid), 32'd1);
    chk({tg, " class"}, 32'(res_class), 32'(cls));
    chk({tg, " err_bits"}, err_bits, err);
    chk("R5 res_pass", 32'(res_pass), 32'(pass));
    chk(pass ? "R8 status" : "R11 status", status_word, st);
    chk("R7 chain_end", 32'(chain_end), 32'(ce));
    chk("R9 done_evt", done_evt, evt);
    chk("R10 wb_req", 32'(wb_req), 32'(wbr));
    chk("R10 wb_word", wb_word, wbw);
  endtask

  task automatic send_words(input int ch, input int upto, input int max_gap);
    for (int k = 0; k < upto; k++) begin
      for (int g = $urandom_range(0, max_gap); g > 0; g--) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_chan  = 3'($urandom_range(0, 5));
        chk("R1 idle", 32'(res_valid), 32'd0);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = d[k];
      in_chan  = (k == 0) ? 3'(ch) : 3'($urandom_range(0, 5));
    end
  endtask

  task automatic send_desc(input int ch, input int max_gap);
    send_words(ch, 16, max_gap);
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict(ch);
  endtask

  // aborts at word k; coincide drives that word in the same cycle
  task automatic abort_at(input int ch, input int k, input bit coincide);
    send_words(ch, k, 0);
    @(negedge clk);
    fetch_err = 1'b1;
    in_valid  = coincide;
    in_word   = d[k];
    in_chan   = (k == 0) ? 3'(ch) : 3'((ch + 1) % 6);
    @(negedge clk);
    fetch_err = 1'b0;
    in_valid  = 1'b0;
    chk("R6 res_valid", 32'(res_valid), 32'd1);
    chk("R6 class", 32'(res_class), 32'd1);
    chk("R6 err_bits", err_bits, 32'd1 << (1 + ch));
    chk("R11 status on fetch", status_word, 32'd0);
    chk("R11 wb_req on fetch", 32'(wb_req), 32'd0);
    @(negedge clk);
    chk("R1 single pulse", 32'(res_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 32'(res_valid), 32'd0);
    chk("R11 reset status", status_word, 32'd0);
    chk("R11 reset wb_word", wb_word, 32'd0);
    chk("R11 reset evt", done_evt, 32'd0);
    rst = 1'b0;

    // directed: pass with all flags
    make_desc(1, 1, 1, 1, 1);
    d[0][8] = 1; d[0][9] = 1; d[0][11] = 1; d[0][18] = 1; d[0][19] = 1; d[0][21] = 1;
    d[15] = csum15();
    send_desc(3, 0);
    // R5 priority: bad preamble beats bad checksum and done
    make_desc(0, 1, 0, 1, 0); send_desc(5, 0);
    // R5 priority: bad checksum beats done
    make_desc(1, 1, 0, 1, 0); send_desc(0, 1);
    // R4 replay
    make_desc(1, 0, 0, 1, 0); send_desc(2, 0);
    // R4 override by ignore-done
    make_desc(1, 0, 0, 1, 1); send_desc(4, 0);
    // R3 checksum disabled, wrong word 15 accepted
    make_desc(1, 0, 0, 0, 0); send_desc(1, 2);

    // R6 aborts: idle, mid-descriptor, coincident with last word
    make_desc(1, 1, 1, 0, 0); abort_at(4, 0, 1);
    make_desc(1, 1, 1, 0, 0); abort_at(2, 7, 0);
    make_desc(1, 1, 1, 0, 0); d[0][8] = 1; d[15] = csum15(); abort_at(5, 15, 1);
    // R6 restart from word 0 after abort
    make_desc(1, 1, 1, 0, 0); d[0][8] = 1; d[15] = csum15(); send_desc(1, 0);

    // R11 reset in mid-descriptor discards the partial one
    make_desc(1, 1, 1, 0, 0);
    send_words(3, 7, 0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 reset mid valid", 32'(res_valid), 32'd0);
    make_desc(1, 1, 1, 0, 0); d[0][9] = 1; d[15] = csum15(); send_desc(0, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int ch = $urandom_range(0, 5);
      make_desc($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) == 0) abort_at(ch, $urandom_range(0, 15), $urandom_range(0, 1) == 1);
      else send_desc(ch, 2);
    end

    @(negedge clk);
    summary();
  end

endmodule